// File: doc/BRIEF.md
# Universal Shift Register with Shared Data Port

This block is a parameterised storage register that on every rising clock edge either keeps its contents, moves them one place toward the most significant end, moves them one place toward the least significant end, or takes a new word in parallel. The parallel input and the parallel output share one data port. The port is modelled as three separate signals so that no real tristate logic is needed: a drive value, a per-bit output-enable vector and a sampled input vector. The surrounding logic resolves the pad or bus from these three signals.

Two select lines choose the operation. Selecting the parallel load releases the shared port, so that an external source can place a word on it and have it captured at the next edge. Two active-low output-control lines decide whether the register drives the port in the other three modes. A synchronous active-low clear overrides every operation. The two end stages are always visible on dedicated serial outputs. Instances can therefore be chained into longer words by wiring the end stage of one instance to the serial input of its neighbour.

Top module: `ushift_reg`

## Requirements
- R1: The operation is chosen by {sel1, sel0}: 2'b00 keeps the contents, 2'b01 shifts toward the MSB, 2'b10 shifts toward the LSB, 2'b11 loads in parallel.
- R2: In keep mode with clear inactive, the register contents stay the same across the edge.
- R3: In MSB-ward shift mode, bit i takes the old bit i-1, bit 0 takes ser_r_in, and the old MSB is dropped.
- R4: In LSB-ward shift mode, bit i takes the old bit i+1, bit WIDTH-1 takes ser_l_in, and the old bit 0 is dropped.
- R5: In load mode, the register captures port_in at the rising edge.
- R6: While sel0 and sel1 are both high, port_oe is all zeros whatever the values of oe_a_n and oe_b_n.
- R7: Outside load mode, port_oe is all ones when oe_a_n and oe_b_n are both low, and all zeros otherwise. port_out always carries the register contents.
- R8: When clr_n is low at a rising edge, every bit becomes zero, whatever mode is selected.
- R9: lsb_out equals bit 0 and msb_out equals bit WIDTH-1 at all times, independent of the output enables.
- R10: Two instances, with the low instance's msb_out feeding the high instance's ser_r_in and the high instance's lsb_out feeding the low instance's ser_l_in, behave as a single register of twice the width in all four modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| sel0 | input | 1 | Operation select, low bit |
| sel1 | input | 1 | Operation select, high bit |
| oe_a_n | input | 1 | Output control A, active low |
| oe_b_n | input | 1 | Output control B, active low |
| ser_r_in | input | 1 | Serial bit entering bit 0 on an MSB-ward shift |
| ser_l_in | input | 1 | Serial bit entering bit WIDTH-1 on an LSB-ward shift |
| port_in | input | WIDTH | Sampled value of the shared data port |
| port_out | output | WIDTH | Value driven onto the shared data port |
| port_oe | output | WIDTH | Per-bit drive enable for the shared data port |
| lsb_out | output | 1 | Bit 0 of the register, for chaining |
| msb_out | output | 1 | Bit WIDTH-1 of the register, for chaining |

## Verification
The bench builds one instance at the default WIDTH of 8. It also builds a pair of WIDTH 8 instances chained into a 16-bit word. The single instance makes the end-of-word cases reachable: a bit falling off either end, and a clear that lands while load mode is selected. The chained pair lets a bit cross the boundary between the two instances in both shift directions, and lets each half load its own word at the same edge.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    // Operation code, indexed as {sel1, sel0}
    typedef enum logic [1:0] {
        OP_KEEP = 2'b00,
        OP_UP   = 2'b01,  // toward the MSB
        OP_DOWN = 2'b10,  // toward the LSB
        OP_LOAD = 2'b11
    } op_e;

endpackage

// File: rtl/ushift_op_dec.sv
module ushift_op_dec
    import ushift_pkg::*;
(
    input  logic clr_n,
    input  logic sel0,
    input  logic sel1,
    output op_e  op,
    output logic zero_all,
    output logic port_release
);

    always_comb begin
        op           = op_e'({sel1, sel0});
        // the clear outranks every operation code
        zero_all     = ~clr_n;
        // the port is released on the select code alone, even during a clear
        port_release = sel0 & sel1;
    end

endmodule

// File: rtl/ushift_next.sv
module ushift_next
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  op_e              op,
    input  logic             zero_all,
    input  logic [WIDTH-1:0] cur,
    input  logic             ser_r,
    input  logic             ser_l,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] from_below;  // source bit for an MSB-ward shift
    logic [WIDTH-1:0] from_above;  // source bit for an LSB-ward shift

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        if (i == 0) begin : g_low_end
            assign from_below[i] = ser_r;
        end else begin : g_low_mid
            assign from_below[i] = cur[i-1];
        end

        if (i == TOP) begin : g_high_end
            assign from_above[i] = ser_l;
        end else begin : g_high_mid
            assign from_above[i] = cur[i+1];
        end

        always_comb begin
            if (zero_all) begin
                nxt[i] = 1'b0;
            end else begin
                unique case (op)
                    OP_KEEP: nxt[i] = cur[i];
                    OP_UP:   nxt[i] = from_below[i];
                    OP_DOWN: nxt[i] = from_above[i];
                    OP_LOAD: nxt[i] = din[i];
                    default: nxt[i] = cur[i];
                endcase
            end
        end
    end

endmodule

// File: rtl/ushift_port_drv.sv
module ushift_port_drv #(
    parameter int WIDTH = 8
) (
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             port_release,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] port_out,
    output logic [WIDTH-1:0] port_oe,
    output logic             lsb_out,
    output logic             msb_out
);

    logic drive;

    always_comb begin
        drive    = ~oe_a_n & ~oe_b_n & ~port_release;
        port_oe  = {WIDTH{drive}};
        port_out = cur;
        lsb_out  = cur[0];
        msb_out  = cur[WIDTH-1];
    end

endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             sel0,
    input  logic             sel1,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             ser_r_in,
    input  logic             ser_l_in,
    input  logic [WIDTH-1:0] port_in,
    output logic [WIDTH-1:0] port_out,
    output logic [WIDTH-1:0] port_oe,
    output logic             lsb_out,
    output logic             msb_out
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } reg_state_t;

    reg_state_t       st_d;
    reg_state_t       st_q;
    op_e              op;
    logic             zero_all;
    logic             port_release;
    logic [WIDTH-1:0] nxt_bits;

    ushift_op_dec u_dec (
        .clr_n        (clr_n),
        .sel0         (sel0),
        .sel1         (sel1),
        .op           (op),
        .zero_all     (zero_all),
        .port_release (port_release)
    );

    ushift_next #(.WIDTH(WIDTH)) u_next (
        .op       (op),
        .zero_all (zero_all),
        .cur      (st_q.bits),
        .ser_r    (ser_r_in),
        .ser_l    (ser_l_in),
        .din      (port_in),
        .nxt      (nxt_bits)
    );

    ushift_port_drv #(.WIDTH(WIDTH)) u_drv (
        .oe_a_n       (oe_a_n),
        .oe_b_n       (oe_b_n),
        .port_release (port_release),
        .cur          (st_q.bits),
        .port_out     (port_out),
        .port_oe      (port_oe),
        .lsb_out      (lsb_out),
        .msb_out      (msb_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt_bits;
    end

    // no reset: the contents are undefined until the first clear or load
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/ushift_reg_chk.sv
module ushift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic             sel0,
    input logic             sel1,
    input logic             oe_a_n,
    input logic             oe_b_n,
    input logic             ser_r_in,
    input logic             ser_l_in,
    input logic [WIDTH-1:0] port_in,
    input logic [WIDTH-1:0] port_out,
    input logic [WIDTH-1:0] port_oe,
    input logic             lsb_out,
    input logic             msb_out
);

    // the contents become known only once a clear has been sampled
    logic armed_q = 1'b0;

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            armed_q <= 1'b1;
        end
    end

    p_clear_r8: assert property (@(posedge clk) disable iff (!armed_q)
        !clr_n |=> port_out == '0);

    // R1 encoding is checked through the four operation properties below
    p_keep_r2: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !sel1 && !sel0) |=> port_out == $past(port_out));

    p_up_r3: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !sel1 && sel0) |=>
            port_out == {$past(port_out[WIDTH-2:0]), $past(ser_r_in)});

    p_down_r4: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && sel1 && !sel0) |=>
            port_out == {$past(ser_l_in), $past(port_out[WIDTH-1:1])});

    p_load_r5: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && sel1 && sel0) |=> port_out == $past(port_in));

    p_release_r6: assert property (@(posedge clk) disable iff (!armed_q)
        (sel1 && sel0) |-> port_oe == '0);

    p_drive_r7: assert property (@(posedge clk) disable iff (!armed_q)
        !(sel1 && sel0) |-> port_oe == ((!oe_a_n && !oe_b_n) ? '1 : '0));

    p_ends_r9: assert property (@(posedge clk) disable iff (!armed_q)
        (lsb_out == port_out[0]) && (msb_out == port_out[WIDTH-1]));

endmodule

bind ushift_reg ushift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .sel0     (sel0),
    .sel1     (sel1),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .ser_r_in (ser_r_in),
    .ser_l_in (ser_l_in),
    .port_in  (port_in),
    .port_out (port_out),
    .port_oe  (port_oe),
    .lsb_out  (lsb_out),
    .msb_out  (msb_out)
);

// File: tb/ushift_reg_tb.sv
`timescale 1ns/1ps
module ushift_reg_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         sel0 = 1'b0;
    logic         sel1 = 1'b0;
    logic         oe_a_n = 1'b1;
    logic         oe_b_n = 1'b1;
    logic         ser_r = 1'b0;
    logic         ser_l = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] port_out;
    logic [W-1:0] port_oe;
    logic         lsb_out;
    logic         msb_out;

    // chained pair
    logic [W-1:0] lo_out, hi_out, lo_oe, hi_oe;
    logic         lo_lsb, lo_msb, hi_lsb, hi_msb;

    int           n_checks = 0;
    int           n_fail = 0;
    bit           finished = 1'b0;

    logic [W-1:0]   m_single;
    logic [2*W-1:0] m_pair;
    logic [3*W-1:0] exp_q[$];
    string          tag_q[$];

    always #2.5 clk = ~clk;

    ushift_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .clr_n(clr_n), .sel0(sel0), .sel1(sel1),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .ser_r_in(ser_r), .ser_l_in(ser_l),
        .port_in(din), .port_out(port_out), .port_oe(port_oe),
        .lsb_out(lsb_out), .msb_out(msb_out)
    );

    ushift_reg #(.WIDTH(W)) u_lo (
        .clk(clk), .clr_n(clr_n), .sel0(sel0), .sel1(sel1),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .ser_r_in(ser_r), .ser_l_in(hi_lsb),
        .port_in(din), .port_out(lo_out), .port_oe(lo_oe),
        .lsb_out(lo_lsb), .msb_out(lo_msb)
    );

    ushift_reg #(.WIDTH(W)) u_hi (
        .clk(clk), .clr_n(clr_n), .sel0(sel0), .sel1(sel1),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .ser_r_in(lo_msb), .ser_l_in(ser_l),
        .port_in(~din), .port_out(hi_out), .port_oe(hi_oe),
        .lsb_out(hi_lsb), .msb_out(hi_msb)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input bit c_n, input logic [1:0] op, input bit sr,
                        input bit sl, input logic [W-1:0] d, input bit oa,
                        input bit ob, input string tag);
        logic [W-1:0] exp_oe;
        @(negedge clk);
        clr_n = c_n; sel1 = op[1]; sel0 = op[0];
        ser_r = sr; ser_l = sl; din = d; oe_a_n = oa; oe_b_n = ob;
        #0.5;
        exp_oe = (op == 2'b11) ? '0 : ((!oa && !ob) ? '1 : '0);
        check(port_oe === exp_oe,
              (op == 2'b11) ? "R6 port released in load" : "R7 output enable",
              {8'h00, port_oe}, {8'h00, exp_oe});
        check({hi_oe, lo_oe} === {exp_oe, exp_oe}, "R10 pair enable",
              {hi_oe, lo_oe}, {exp_oe, exp_oe});
        if (!c_n) begin
            m_single = '0;
            m_pair   = '0;
        end else begin
            case (op)
                2'b00: ;
                2'b01: begin
                    m_single = {m_single[W-2:0], sr};
                    m_pair   = {m_pair[2*W-2:0], sr};
                end
                2'b10: begin
                    m_single = {sl, m_single[W-1:1]};
                    m_pair   = {sl, m_pair[2*W-1:1]};
                end
                default: begin
                    m_single = d;
                    m_pair   = {~d, d};
                end
            endcase
        end
        exp_q.push_back({m_pair, m_single});
        tag_q.push_back(tag);
    endtask

    // monitor: compares results one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                automatic logic [3*W-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(port_out === e[W-1:0], t, {8'h00, port_out}, {8'h00, e[W-1:0]});
                check({msb_out, lsb_out} === {e[W-1], e[0]}, "R9 end stage outputs",
                      {14'h0, msb_out, lsb_out}, {14'h0, e[W-1], e[0]});
                check({hi_out, lo_out} === e[3*W-1:W], {"R10 pair ", t},
                      {hi_out, lo_out}, e[3*W-1:W]);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pat;
        m_single = 'x;
        m_pair   = 'x;
        repeat (3) @(posedge clk);
        // R8 first clear gives a known state
        step(1'b0, 2'b00, 0, 0, 8'hFF, 0, 0, "R8 clear from unknown");
        // R5 load with both enables asserted: port still released (R6)
        step(1'b1, 2'b11, 0, 0, 8'hA5, 0, 0, "R5 load A5");
        // R2 keep under each enable combination (R7)
        step(1'b1, 2'b00, 1, 1, 8'h00, 0, 0, "R2 keep");
        step(1'b1, 2'b00, 1, 1, 8'hFF, 0, 1, "R2 keep oe_b high");
        step(1'b1, 2'b00, 0, 1, 8'h3C, 1, 0, "R2 keep oe_a high");
        step(1'b1, 2'b00, 0, 0, 8'h3C, 1, 1, "R2 keep both high");
        // R1/R3 MSB-ward shifts
        step(1'b1, 2'b01, 1, 0, 8'h00, 0, 0, "R3 shift up ser 1");
        step(1'b1, 2'b01, 0, 1, 8'hFF, 0, 0, "R3 shift up ser 0");
        // R1/R4 LSB-ward shifts
        step(1'b1, 2'b10, 0, 1, 8'h00, 0, 0, "R4 shift down ser 1");
        step(1'b1, 2'b10, 1, 0, 8'hFF, 0, 0, "R4 shift down ser 0");
        // R8 clear outranks load
        step(1'b1, 2'b11, 0, 0, 8'h3C, 1, 1, "R5 load 3C");
        step(1'b0, 2'b11, 0, 0, 8'hFF, 0, 0, "R8 clear over load");
        step(1'b1, 2'b10, 0, 0, 8'h00, 0, 0, "R4 after clear");
        step(1'b0, 2'b01, 1, 1, 8'h00, 0, 0, "R8 clear over shift");
        // R3 MSB falls off the top end
        step(1'b1, 2'b11, 0, 0, 8'h80, 0, 0, "R5 load 80");
        step(1'b1, 2'b01, 0, 0, 8'h00, 0, 0, "R3 msb dropped");
        // R4 bit 0 falls off the bottom end
        step(1'b1, 2'b11, 0, 0, 8'h01, 0, 0, "R5 load 01");
        step(1'b1, 2'b10, 0, 0, 8'h00, 0, 0, "R4 lsb dropped");
        // R10 cross the instance boundary in both directions
        step(1'b1, 2'b11, 0, 0, 8'h81, 0, 0, "R5 load 81 pair 7E81");
        for (int i = 0; i < 9; i++) begin
            step(1'b1, 2'b01, i[0], 0, 8'h00, 0, 0, "R10 pair shift up");
        end
        for (int i = 0; i < 9; i++) begin
            step(1'b1, 2'b10, 0, i[1], 8'h00, 0, 0, "R10 pair shift down");
        end
        // R1 mixed sequence of all codes
        pat = 8'h5B;
        for (int i = 0; i < 48; i++) begin
            pat = {pat[6:0], pat[7] ^ pat[5] ^ pat[4] ^ pat[3]};
            step((i % 17) != 16, pat[1:0], pat[2], pat[3], pat ^ 8'hC3,
                 pat[4], pat[5], "R1 mixed operations");
        end
        step(1'b1, 2'b00, 0, 0, 8'h00, 0, 0, "R2 final keep");
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule